// File: doc/BRIEF.md
# Button-Driven Bounded Value Stepper

This block keeps two 7-bit values, X and Y, and moves them one unit at a time in response to a byte of button states sampled on a scan strobe. Each axis is armed by its own modifier button; while armed, a held direction button feeds an 8-bit accumulator for that direction, and the value steps when the accumulator's bit 3 becomes set. Y accumulates faster than X, so a held button repeats on Y every third scan and on X every fourth. Values stop at 0 and 0x7F.

Pressing select or start returns both values to the centre (0x40). A slow housekeeping tick wipes all accumulators so that partial progress does not linger. Each axis has a one-cycle changed strobe that a downstream message queue uses to know when to send the new value.

Top module: `button_value_stepper`

## Requirements
- R1: After reset both values are 0x40, both changed strobes are low, and all four accumulators are zero.
- R2: The button byte is active high with bit0 = A, bit1 = B, bit2 = select, bit3 = start, bit4 = up, bit5 = down, bit6 = left, bit7 = right. A scan with select or start set loads 0x40 into both values and performs no accumulation or stepping.
- R3: Y reacts only when B is held in the scan; up (bit4) raises Y by one and down (bit5) lowers it by one.
- R4: X reacts only when A is held in the scan; left (bit6) lowers X by one and right (bit7) raises it by one.
- R5: A held direction adds 3 per scan to its accumulator on Y and 2 per scan on X; a step happens when bit 3 of the updated accumulator is set, so from zero Y steps on the third held scan and X on the fourth.
- R6: A step on an axis clears both accumulators of that axis, including the one for the opposite direction.
- R7: Within a scan, up is evaluated before down and left before right, each seeing the result of the previous one; with both directions of Y held from zero, Y is 0x41 after three scans and back to 0x40 after five; with both of X held, X is 0x3F after four scans and 0x40 after seven.
- R8: Values saturate at 0 and 0x7F; a direction that fires at a limit does not step and does not clear the accumulators.
- R9: A housekeeping tick clears all four accumulators; when it coincides with a scan, the scan is processed first and its accumulator results are then cleared.
- R10: An axis's changed strobe is high for exactly the cycle after a scan in which that axis's value differs from its value before the scan, recentering included; a recenter that leaves a value at 0x40 gives no strobe.
- R11: Without a scan strobe, button changes have no effect on the values or the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_stb | input | 1 | One-cycle strobe: process btn_state this cycle |
| house_tick | input | 1 | Housekeeping pulse clearing all accumulators |
| btn_state | input | 8 | Button byte, active high, fields per R2 |
| x_val | output | 7 | Current X value |
| y_val | output | 7 | Current Y value |
| x_chg | output | 1 | X changed strobe |
| y_chg | output | 1 | Y changed strobe |

## Verification
The checker watches every cycle that recentering lands both values on 0x40, that an unarmed axis holds still, that a value moves by at most one per scan, that nothing moves or strobes without a scan, and that each strobe matches a real value change. The repeat rate, the cross-clearing of accumulators, the in-scan ordering, the saturation behaviour of the accumulators and the effect of the housekeeping tick depend on hidden accumulator history, so only the bench's scenarios, counting scans and watching when the steps arrive, can show them.

// File: rtl/vstep_pkg.sv
// Shared definitions for the bounded value stepper.
// Assumes the button byte layout given in the brief (active high).
package vstep_pkg;
    localparam int BTN_W = 8;

    // Decoded view of the button byte.
    typedef struct packed {
        logic arm_x;
        logic arm_y;
        logic recenter;
        logic up;
        logic down;
        logic left;
        logic right;
    } vstep_btn_t;

    // Bit positions inside the button byte.
    localparam int BIT_ARM_X  = 0;
    localparam int BIT_ARM_Y  = 1;
    localparam int BIT_SELECT = 2;
    localparam int BIT_START  = 3;
    localparam int BIT_UP     = 4;
    localparam int BIT_DOWN   = 5;
    localparam int BIT_LEFT   = 6;
    localparam int BIT_RIGHT  = 7;
endpackage

// File: rtl/vstep_btn_decode.sv
// Splits the raw button byte into named controls.
// Assumes active-high buttons; select and start share the recenter action.
module vstep_btn_decode
    import vstep_pkg::*;
(
    input  logic [BTN_W-1:0] raw,
    output vstep_btn_t       btn
);
    // Pure field extraction.
    always_comb begin
        btn.arm_x    = raw[BIT_ARM_X];
        btn.arm_y    = raw[BIT_ARM_Y];
        btn.recenter = raw[BIT_SELECT] | raw[BIT_START];
        btn.up       = raw[BIT_UP];
        btn.down     = raw[BIT_DOWN];
        btn.left     = raw[BIT_LEFT];
        btn.right    = raw[BIT_RIGHT];
    end
endmodule

// File: rtl/vstep_axis.sv
// One axis: a saturating value with a pair of direction accumulators.
// Each held, armed direction adds INC to its accumulator; when bit FIRE_BIT
// of the result is set and the value is not at the matching limit, the value
// moves one unit and both accumulators clear. NEG_FIRST picks which
// direction is evaluated first within a scan. Assumes scan is a pulse.
module vstep_axis #(
    parameter int VAL_W     = 7,
    parameter int ACC_W     = 8,
    parameter int FIRE_BIT  = 3,
    parameter int INC       = 3,
    parameter int CENTER    = 64,
    parameter bit NEG_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan,
    input  logic             tick,
    input  logic             recenter,
    input  logic             en,
    input  logic             pos_req,
    input  logic             neg_req,
    output logic [VAL_W-1:0] val,
    output logic             chg
);
    localparam logic [VAL_W-1:0] MAX_V    = {VAL_W{1'b1}};
    localparam logic [VAL_W-1:0] MIN_V    = '0;
    localparam logic [VAL_W-1:0] CENTER_V = VAL_W'(CENTER);
    localparam logic [ACC_W-1:0] INC_V    = ACC_W'(INC);

    logic [VAL_W-1:0] val_q, val_n;
    logic [ACC_W-1:0] accp_q, accn_q, accp_n, accn_n;
    logic             chg_q;
    logic             pick_pos;

    // Evaluate both directions in order, each seeing the previous result.
    always_comb begin
        val_n    = val_q;
        accp_n   = accp_q;
        accn_n   = accn_q;
        pick_pos = 1'b0;
        for (int k = 0; k < 2; k++) begin
            pick_pos = NEG_FIRST ? (k == 1) : (k == 0);
            if (pick_pos) begin
                if (en && pos_req) begin
                    accp_n = accp_n + INC_V;
                    if (accp_n[FIRE_BIT] && (val_n != MAX_V)) begin
                        val_n  = val_n + 1'b1;
                        accp_n = '0;
                        accn_n = '0;
                    end
                end
            end else begin
                if (en && neg_req) begin
                    accn_n = accn_n + INC_V;
                    if (accn_n[FIRE_BIT] && (val_n != MIN_V)) begin
                        val_n  = val_n - 1'b1;
                        accp_n = '0;
                        accn_n = '0;
                    end
                end
            end
        end
    end

    // State update: recenter or step on a scan, then tick clears accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= CENTER_V;
            accp_q <= '0;
            accn_q <= '0;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (scan) begin
                if (recenter) begin
                    val_q <= CENTER_V;
                    chg_q <= (val_q != CENTER_V);
                end else begin
                    val_q  <= val_n;
                    accp_q <= accp_n;
                    accn_q <= accn_n;
                    chg_q  <= (val_n != val_q);
                end
            end
            if (tick) begin
                accp_q <= '0;
                accn_q <= '0;
            end
        end
    end

    assign val = val_q;
    assign chg = chg_q;
endmodule

// File: rtl/button_value_stepper.sv
// Top: decodes the button byte and drives two axis steppers.
// Y (armed by B) uses the faster increment and evaluates up first;
// X (armed by A) uses the slower increment and evaluates left first.
module button_value_stepper
    import vstep_pkg::*;
#(
    parameter int VAL_W    = 7,
    parameter int ACC_W    = 8,
    parameter int FIRE_BIT = 3,
    parameter int Y_INC    = 3,
    parameter int X_INC    = 2,
    parameter int CENTER   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_stb,
    input  logic             house_tick,
    input  logic [7:0]       btn_state,
    output logic [VAL_W-1:0] x_val,
    output logic [VAL_W-1:0] y_val,
    output logic             x_chg,
    output logic             y_chg
);
    vstep_btn_t btn;

    vstep_btn_decode u_dec (
        .raw (btn_state),
        .btn (btn)
    );

    vstep_axis #(
        .VAL_W(VAL_W), .ACC_W(ACC_W), .FIRE_BIT(FIRE_BIT),
        .INC(Y_INC), .CENTER(CENTER), .NEG_FIRST(1'b0)
    ) u_y (
        .clk(clk), .rst_n(rst_n), .scan(scan_stb), .tick(house_tick),
        .recenter(btn.recenter), .en(btn.arm_y),
        .pos_req(btn.up), .neg_req(btn.down),
        .val(y_val), .chg(y_chg)
    );

    vstep_axis #(
        .VAL_W(VAL_W), .ACC_W(ACC_W), .FIRE_BIT(FIRE_BIT),
        .INC(X_INC), .CENTER(CENTER), .NEG_FIRST(1'b1)
    ) u_x (
        .clk(clk), .rst_n(rst_n), .scan(scan_stb), .tick(house_tick),
        .recenter(btn.recenter), .en(btn.arm_x),
        .pos_req(btn.right), .neg_req(btn.left),
        .val(x_val), .chg(x_chg)
    );
endmodule

// File: rtl/vstep_checker.sv
// Cycle-level properties of the stepper, attached to the top by bind.
// Assumes the button layout of the brief and a 7-bit value width.
module vstep_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scan_stb,
    input logic [7:0] btn_state,
    input logic [6:0] x_val,
    input logic [6:0] y_val,
    input logic       x_chg,
    input logic       y_chg
);
    logic rc;
    assign rc = btn_state[2] | btn_state[3];

    // R2: recenter lands both values on the centre.
    a_r2_recenter: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb && rc |=> (x_val == 7'h40) && (y_val == 7'h40));

    // R3: Y holds when B is not held.
    a_r3_y_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb && !rc && !btn_state[1] |=> $stable(y_val));

    // R4: X holds when A is not held.
    a_r4_x_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb && !rc && !btn_state[0] |=> $stable(x_val));

    // R5: a scan moves Y by at most one unit.
    a_r5_y_unit: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb && !rc |=> ($stable(y_val) ||
            ({1'b0, y_val} == {1'b0, $past(y_val)} + 8'd1) ||
            ({1'b0, y_val} + 8'd1 == {1'b0, $past(y_val)})));

    // R5: a scan moves X by at most one unit.
    a_r5_x_unit: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb && !rc |=> ($stable(x_val) ||
            ({1'b0, x_val} == {1'b0, $past(x_val)} + 8'd1) ||
            ({1'b0, x_val} + 8'd1 == {1'b0, $past(x_val)})));

    // R11: no scan, no movement and no strobe.
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_stb |=> $stable(x_val) && $stable(y_val) && !x_chg && !y_chg);

    // R10: a strobe always accompanies a real change of its value.
    a_r10_x_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb |=> (x_chg == (x_val != $past(x_val))));
    a_r10_y_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        scan_stb |=> (y_chg == (y_val != $past(y_val))));
endmodule

bind button_value_stepper vstep_checker u_vstep_chk (
    .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .btn_state(btn_state),
    .x_val(x_val), .y_val(y_val), .x_chg(x_chg), .y_chg(y_chg)
);

// File: tb/tb_button_value_stepper.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_button_value_stepper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_stb = 1'b0;
    logic       house_tick = 1'b0;
    logic [7:0] btn_state = 8'h00;
    logic [6:0] x_val, y_val;
    logic       x_chg, y_chg;
    int n_chk = 0;
    int n_fail = 0;
    logic last_xc, last_yc;

    localparam logic [7:0] A = 8'h01, B = 8'h02, SEL = 8'h04, STA = 8'h08;
    localparam logic [7:0] UP = 8'h10, DN = 8'h20, LF = 8'h40, RT = 8'h80;

    always #5 clk = ~clk;

    button_value_stepper dut (
        .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .house_tick(house_tick),
        .btn_state(btn_state), .x_val(x_val), .y_val(y_val),
        .x_chg(x_chg), .y_chg(y_chg)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scan_stb = 1'b0; house_tick = 1'b0; btn_state = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One scan; values and strobes are sampled at the following falling edge.
    task automatic scan(input logic [7:0] b, input logic tk = 1'b0);
        btn_state = b; scan_stb = 1'b1; house_tick = tk;
        @(negedge clk);
        scan_stb = 1'b0; house_tick = 1'b0;
        last_xc = x_chg; last_yc = y_chg;
    endtask

    task automatic scans(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) scan(b);
    endtask

    task automatic t_reset_rate();
        do_reset();
        chk("R1 x after reset", x_val, 8'h40);
        chk("R1 y after reset", y_val, 8'h40);
        chk("R1 strobes after reset", {x_chg, y_chg}, 0);
        scans(B | UP, 2);
        chk("R5 y no step after 2 scans", y_val, 8'h40);
        scan(B | UP);
        chk("R5 y steps on 3rd scan", y_val, 8'h41);
        chk("R10 y strobe on step", last_yc, 1);
        chk("R10 x no strobe", last_xc, 0);
        @(negedge clk);
        chk("R10 y strobe one cycle", y_chg, 0);
        scans(A | RT, 3);
        chk("R5 x no step after 3 scans", x_val, 8'h40);
        scan(A | RT);
        chk("R5 x steps on 4th scan", x_val, 8'h41);
    endtask

    task automatic t_recenter();
        do_reset();
        scans(B | UP, 3);
        scan(SEL | B | UP);
        chk("R2 select recenters y", y_val, 8'h40);
        chk("R10 strobe on recenter", last_yc, 1);
        chk("R10 no x strobe when x at centre", last_xc, 0);
        scans(A | RT, 4);
        scan(STA | A | RT);
        chk("R2 start recenters x", x_val, 8'h40);
        scan(STA);
        chk("R10 no strobe recenter at centre", {last_xc, last_yc}, 0);
    endtask

    task automatic t_gating();
        do_reset();
        scans(UP, 5);
        chk("R3 up without B ignored", y_val, 8'h40);
        scans(RT | B, 5);
        chk("R4 right without A ignored", x_val, 8'h40);
        scans(A | LF, 4);
        chk("R4 left decrements x", x_val, 8'h3F);
        scans(B | DN, 3);
        chk("R3 down decrements y", y_val, 8'h3F);
    endtask

    task automatic t_order();
        do_reset();
        scans(B | UP | DN, 3);
        chk("R7 up first after 3 scans", y_val, 8'h41);
        scans(B | UP | DN, 2);
        chk("R7 down after 5 scans", y_val, 8'h40);
        scans(A | LF | RT, 4);
        chk("R7 left first after 4 scans", x_val, 8'h3F);
        scans(A | LF | RT, 3);
        chk("R7 right after 7 scans", x_val, 8'h40);
        do_reset();
        scans(B | DN, 2);
        scans(B | UP, 3);
        chk("R6 up step", y_val, 8'h41);
        scans(B | DN, 2);
        chk("R6 down acc was cleared", y_val, 8'h41);
        scan(B | DN);
        chk("R6 down steps after 3 fresh scans", y_val, 8'h40);
    endtask

    task automatic t_saturate();
        do_reset();
        scans(B | UP, 189);
        chk("R8 y reaches max", y_val, 8'h7F);
        scans(B | UP, 3);
        chk("R8 y holds at max", y_val, 8'h7F);
        chk("R8 no strobe at max", last_yc, 0);
        scan(SEL);
        scan(B | UP);
        chk("R8 acc kept at limit steps at once", y_val, 8'h41);
        scans(A | LF, 256);
        chk("R8 x reaches zero", x_val, 8'h00);
        scans(A | LF, 4);
        chk("R8 x holds at zero", x_val, 8'h00);
    endtask

    task automatic t_tick();
        do_reset();
        scans(B | UP, 2);
        house_tick = 1'b1;
        @(negedge clk);
        house_tick = 1'b0;
        scans(B | UP, 2);
        chk("R9 tick cleared accs", y_val, 8'h40);
        scan(B | UP);
        chk("R9 step after 3 fresh scans", y_val, 8'h41);
        do_reset();
        scan(B | UP, 1'b1);
        scans(B | UP, 2);
        chk("R9 coincident tick cleared scan result", y_val, 8'h40);
        scan(B | UP);
        chk("R9 step after coincident tick", y_val, 8'h41);
    endtask

    task automatic t_idle();
        do_reset();
        btn_state = B | UP | A | RT | SEL;
        repeat (10) begin
            @(negedge clk);
            chk("R11 no strobe without scan", {x_chg, y_chg}, 0);
        end
        btn_state = 8'h00;
        scans(B | UP, 2);
        chk("R11 buttons without scan did not accumulate", y_val, 8'h40);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_rate();
        t_recenter();
        t_gating();
        t_order();
        t_saturate();
        t_tick();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule